// File: doc/BRIEF.md
# Interrupt Pending and Active Tracker

This block keeps three bits of state for each of a small set of interrupt request lines: pending, active and enabled. Every clock edge samples the request inputs. A line seen high becomes pending whatever its enable bit says. Enabling a line therefore never discards a request that arrived while the line was masked. The enable bit only decides whether a pending line may be handed to the core.

When no line is active, the lowest-numbered line that is both pending and enabled is offered to the core. An acknowledge takes that line: a one-cycle strobe carries its index, the line becomes active and its pending bit clears. A request that arrives during the active period pends the line again, so a line can be active and pending at the same time. Any number of pulses during that period count as a single event. An exception-return strobe ends the active period.

Software has three per-line write strobes: set enable, clear enable and clear pending. All the state is visible on output ports.

Top module: `irq_tracker`

## Requirements
- R1: After reset the pending, active and enable vectors are all zero, and `req` and `take_vld` are low.
- R2: A request input that is high at a rising clock edge sets that line's pending bit after that edge, whether or not the line is enabled.
- R3: Setting the enable bit of a line that is already pending leaves pending set, and the line becomes eligible in the cycle after the enable write.
- R4: `en_set[i]` sets and `en_clr[i]` clears enable bit i at the next edge; if both are high in the same cycle the clear wins. Enable writes never change pending bits.
- R5: `pend_clr[i]` clears pending bit i at the next edge without touching the enable bit. If the request input of that line is high in the same cycle, the input wins and pending stays set.
- R6: While no line is active, `req` is high exactly when some line is pending and enabled. With `ack` high in such a cycle, `take_vld` is high in that same cycle and `take_idx` is the lowest-numbered eligible line.
- R7: After a take, the taken line's active bit is set and its pending bit is cleared at the next edge, unless its input is high in the take cycle. At most one line is active at a time.
- R8: While any line is active, `req` and `take_vld` stay low even with `ack` high.
- R9: A request on the active line pends it again. Several pulses during the active period leave exactly one pending event, which is taken once after return.
- R10: `eret` clears the active bit at the next edge. If the request input is still high at that edge, pending is set again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_LINES | Request inputs, sampled each edge |
| en_set | input | N_LINES | Per-line set-enable strobes |
| en_clr | input | N_LINES | Per-line clear-enable strobes |
| pend_clr | input | N_LINES | Per-line clear-pending strobes |
| ack | input | 1 | Core acknowledge |
| eret | input | 1 | Exception-return strobe |
| req | output | 1 | A line is eligible and none is active |
| take_vld | output | 1 | One-cycle strobe: a line is taken this cycle |
| take_idx | output | IW | Index of the taken line |
| pend_o | output | N_LINES | Pending bits |
| act_o | output | N_LINES | Active bits |
| en_o | output | N_LINES | Enable bits |

## Verification
The bench builds the block with N_LINES = 4. At that size all 16 request patterns can be swept with every line masked, and all 15 non-empty pending patterns can be swept with every line enabled. The expected taken index is the lowest set bit, which the bench finds with the two's-complement isolation trick. Directed sequences cover the other cases: a request latched while masked, a pulse burst during the active period, clear-pending and exception return with the input still high, and a set and a clear of enable in the same cycle.

// File: rtl/irq_tracker.sv
module irq_tracker #(
  parameter int N_LINES = 8,
  localparam int IW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic [N_LINES-1:0] en_set,
  input  logic [N_LINES-1:0] en_clr,
  input  logic [N_LINES-1:0] pend_clr,
  input  logic               ack,
  input  logic               eret,
  output logic               req,
  output logic               take_vld,
  output logic [IW-1:0]      take_idx,
  output logic [N_LINES-1:0] pend_o,
  output logic [N_LINES-1:0] act_o,
  output logic [N_LINES-1:0] en_o
);

  logic [N_LINES-1:0] pend, act, en;
  logic [N_LINES-1:0] elig, sel_oh, take_oh;
  logic               busy;

  assign elig     = pend & en;
  assign sel_oh   = elig & (~elig + 1'b1);
  assign busy     = |act;
  assign req      = (|elig) & ~busy;
  assign take_vld = req & ack;
  assign take_oh  = take_vld ? sel_oh : '0;

  always_comb begin
    take_idx = '0;
    for (int i = N_LINES - 1; i >= 0; i--)
      if (elig[i]) take_idx = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      act  <= '0;
      en   <= '0;
    end else begin
      pend <= (pend & ~pend_clr & ~take_oh) | irq_in;
      en   <= (en | en_set) & ~en_clr;
      act  <= (eret ? '0 : act) | take_oh;
    end
  end

  assign pend_o = pend;
  assign act_o  = act;
  assign en_o   = en;

  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(act)) else $error("more than one line active"); // R7
  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !take_vld) else $error("take while active"); // R8
  AST_TAKE_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n) take_vld |=> act[$past(take_idx)]) else $error("taken line not active"); // R7
  AST_ERET_ENDS: assert property (@(posedge clk) disable iff (!rst_n) eret |=> (act == '0)) else $error("active survives return"); // R10

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    AST_PEND_LATCH: assert property (@(posedge clk) disable iff (!rst_n) irq_in[g] |=> pend[g]) else $error("request not latched"); // R2
    AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n) (pend_clr[g] && !irq_in[g]) |=> !pend[g]) else $error("pending not cleared"); // R5
    AST_EN_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n) en_clr[g] |=> !en[g]) else $error("enable not cleared"); // R4
  end

endmodule

// File: tb/irq_tracker_bench.sv
`timescale 1ns/1ps
module irq_tracker_bench;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq_in = '0, en_set = '0, en_clr = '0, pend_clr = '0;
  logic ack = 1'b0, eret = 1'b0;
  logic req, take_vld;
  logic [IW-1:0] take_idx;
  logic [N-1:0] pend_o, act_o, en_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_tracker #(.N_LINES(N)) u_irq_tracker (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .en_set(en_set), .en_clr(en_clr),
    .pend_clr(pend_clr), .ack(ack), .eret(eret), .req(req), .take_vld(take_vld),
    .take_idx(take_idx), .pend_o(pend_o), .act_o(act_o), .en_o(en_o));

  task automatic chk(input bit ok, input string r, input int a, input int e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, a, e);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    irq_in = '0; en_set = '0; en_clr = '0; pend_clr = '0; ack = 1'b0; eret = 1'b0;
  endtask

  task automatic flush();
    eret = 1'b1; pend_clr = '1; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk(pend_o == 0 && act_o == 0 && en_o == 0, "R1 state", {pend_o, act_o, en_o}, 0);
    chk(!req && !take_vld, "R1 strobes", {req, take_vld}, 0);
    rst_n = 1'b1;
    tick();

    // R2 sweep every pattern while masked
    for (int m = 0; m < 16; m++) begin
      irq_in = N'(m); tick();
      chk(pend_o == N'(m), "R2 latch while masked", pend_o, m);
      chk(!req, "R6 no req when masked", req, 0);
      flush();
    end

    // R3 enable after pending
    irq_in = 4'b0001; tick();
    chk(!req, "R3 masked no req", req, 0);
    en_set = 4'b0001; tick();
    chk(pend_o[0] && req, "R3 pending kept, req up", {pend_o[0], req}, 3);
    flush();

    // R4 enable writes
    en_set = 4'b1111; en_clr = 4'b1000; tick();
    chk(en_o == 4'b0111, "R4 clear wins", en_o, 7);
    irq_in = 4'b0100; tick();
    en_clr = 4'b0100; tick();
    chk(en_o == 4'b0011 && pend_o == 4'b0100, "R4 pending untouched", {en_o, pend_o}, 8'h34);
    en_set = 4'b1100; tick();
    flush();

    // R5 clear pending
    irq_in = 4'b0010; tick();
    pend_clr = 4'b0010; tick();
    chk(pend_o == 0 && en_o == 4'b1111, "R5 clear keeps enable", {pend_o, en_o}, 15);
    irq_in = 4'b0010; tick();
    irq_in = 4'b0010; pend_clr = 4'b0010; tick();
    chk(pend_o == 4'b0010, "R5 input wins", pend_o, 2);
    flush();

    // R6 R7 R8 priority sweep, all enabled
    for (int m = 1; m < 16; m++) begin
      logic [N-1:0] oh;
      int lo;
      oh = N'(m) & (~N'(m) + 1'b1);
      lo = $clog2(int'(oh));
      irq_in = N'(m); tick();
      chk(req, "R6 req", req, 1);
      ack = 1'b1; #1;
      chk(take_vld && take_idx == IW'(lo), "R6 lowest index", take_idx, lo);
      tick();
      chk(act_o == oh && pend_o == (N'(m) & ~oh), "R7 active set pend cleared", {act_o, pend_o}, {oh, N'(m) & ~oh});
      ack = 1'b1; #1;
      chk(!take_vld && !req, "R8 blocked while active", {req, take_vld}, 0);
      flush();
    end

    // R7 input high during take keeps pending
    irq_in = 4'b0010; tick();
    irq_in = 4'b0010; ack = 1'b1; tick();
    chk(act_o == 4'b0010 && pend_o == 4'b0010, "R7 input high at take", {act_o, pend_o}, 8'h22);
    flush();

    // R9 pulse burst during active
    irq_in = 4'b0100; tick();
    ack = 1'b1; tick();
    for (int k = 0; k < 3; k++) begin
      irq_in = 4'b0100; tick(); tick();
    end
    chk(act_o == 4'b0100 && pend_o == 4'b0100, "R9 active and pending", {act_o, pend_o}, 8'h44);
    eret = 1'b1; tick();
    chk(act_o == 0 && req, "R10 return", {act_o, req}, 1);
    ack = 1'b1; #1;
    chk(take_vld && take_idx == 2'd2, "R9 retaken once", take_idx, 2);
    tick();
    eret = 1'b1; tick();
    chk(!req && pend_o == 0, "R9 single event", {req, pend_o}, 0);

    // R10 input still high at return
    irq_in = 4'b1000; tick();
    ack = 1'b1; tick();
    irq_in = 4'b1000; eret = 1'b1; tick();
    chk(act_o == 0 && pend_o == 4'b1000, "R10 re-pend at return", {act_o, pend_o}, 8);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule